// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block models the command front end of a NOR flash array together with the sequencer that runs program and erase operations. A host drives it with separate chip-enable, write-enable and output-enable strobes, all active low. It also drives an address bus and a data bus. A width select chooses between byte access and 16-bit word access. The host writes command sequences in ordinary bus write cycles. Each write cycle latches its address and its data. The command decoder turns a complete sequence into one of three operations: program one location, erase one sector, or erase the whole array.

A program operation holds its pulse for a set number of clock cycles and then stores the new value. An erase operation first walks the target range and programs every word that is not already all zeros. It then runs a timed erase pulse, after which the whole target reads as erased (all ones). While an operation runs, a read returns status instead of array data, and the ready output is low. When the operation finishes, the block returns to read-array mode by itself. A low-supply input blocks every write cycle.

The array is a small register file of 16-bit words split into equal sectors. All durations are parameters counted in clock cycles.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready` is 1 and every location reads erased: 16'hFFFF in word mode and 16'h00FF in byte mode.
- R2: A program runs after four write cycles: 8'hAA at an address whose low four bits are 4'h5, then 8'h55 at low bits 4'hA, then 8'hA0 at low bits 4'h5, then the data at the target address. When the operation completes, the target reads back as its old value ANDed with the data.
- R3: In byte mode (`word_mode`=0), address bit 0 picks the byte within a word (0 = low byte, 1 = high byte). The word index is the address shifted right by one, only `din[7:0]` is used, only the chosen byte changes, and reads return that byte with `dout[15:8]`=0. In word mode the word index is `addr[4:0]` and `addr[5]` is ignored.
- R4: Programming can only clear bits. A bit that is already 0 stays 0 whatever data is written.
- R5: During a busy read, `dout[7]` is the complement of bit 7 of the written data for a program, and 0 for an erase. `dout[5:0]` and `dout[15:8]` read 0.
- R6: `dout[6]` inverts at every new read (a high-to-low edge of `oe_n` with `ce_n` low) while busy. While idle, reads return plain array data and consecutive reads agree.
- R7: `ready` is low from the cycle after the final command write until completion. A program keeps it low for exactly PROG_CYC cycles.
- R8: A sector erase runs after six write cycles: AA@5, 55@A, 80@5, AA@5, 55@A, then 8'h30 at any address in the target sector (sector = word index bits [4:3]). Afterwards that sector reads 16'hFFFF and other sectors are unchanged. It stays busy for (words) + (nonzero words)·PRE_CYC + ERASE_CYC cycles.
- R9: The same sequence ending in 8'h10 erases the whole array, with the same busy-length rule over all 32 words.
- R10: While `low_vdd` is 1, write cycles are ignored: no operation starts and the array is unchanged.
- R11: Write cycles made while busy are ignored. A write that does not match the next expected step returns the decoder to read mode without starting anything.
- R12: On completion, the block returns to read-array mode without any command, and the target address reads its true stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a high-to-low edge with ce_n low is one write cycle |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit word access, 0 = byte access |
| low_vdd | input | 1 | Low-supply detect; 1 blocks all writes |
| addr | input | 6 | Address (word index, or word index and byte select) |
| din | input | 16 | Write data |
| dout | output | 16 | Read data or status; 0 when ce_n or oe_n is high |
| ready | output | 1 | 1 = idle, 0 = operation in progress |

## Verification
A decoder stuck in a wrong step shows up at the first `ready` sample after the final write. Either `ready` fails to drop, or it drops when it should not. A wrong sequencer count or a missed preprogram skip changes the exact number of low `ready` cycles, which the bench counts for every operation. A wrong byte lane, a bad AND merge or an erase that spills into another sector is visible on the readback that follows. Wrong status polarity or a toggle that sticks is visible within one or two busy reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CMD_AW  = 4;

    localparam logic [BYTE_W-1:0] CMD_KEY1  = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_KEY2  = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_PROG  = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_ERASE = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_SECT  = 8'h30;
    localparam logic [BYTE_W-1:0] CMD_CHIP  = 8'h10;

    localparam logic [CMD_AW-1:0] KEY_ADR1 = 4'h5;
    localparam logic [CMD_AW-1:0] KEY_ADR2 = 4'hA;

    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SERASE,
        OP_CERASE
    } op_e;

    typedef enum logic [2:0] {
        C_READ,
        C_K1,
        C_K2,
        C_PGM,
        C_E1,
        C_E2,
        C_E3
    } cmd_st_e;

    typedef enum logic [2:0] {
        E_IDLE,
        E_PROG,
        E_SCAN,
        E_PULSE,
        E_ERASE
    } eng_st_e;

    // Programming only clears bits; a byte write leaves the other lane alone.
    function automatic logic [DATA_W-1:0] prog_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] d,
        input logic              wide,
        input logic              hi
    );
        logic [DATA_W-1:0] mask;
        if (wide)
            mask = d;
        else if (hi)
            mask = {d[BYTE_W-1:0], {BYTE_W{1'b1}}};
        else
            mask = {{BYTE_W{1'b1}}, d[BYTE_W-1:0]};
        return old_w & mask;
    endfunction

endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if
    import flash_seq_pkg::*;
#(
    parameter int ABW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              low_vdd,
    input  logic              word_mode,
    input  logic [ABW-1:0]    addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_vld,
    output logic [ABW-1:0]    wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_wide,
    output logic              rd_start
);

    logic we_q;
    logic oe_q;
    logic wr_edge;

    assign wr_edge  = !ce_n && !we_n && we_q;
    assign rd_start = !ce_n && !oe_n && oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            oe_q    <= 1'b1;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_wide <= 1'b1;
        end else begin
            we_q   <= we_n;
            oe_q   <= oe_n;
            wr_vld <= wr_edge && !low_vdd;
            if (wr_edge && !low_vdd) begin
                wr_addr <= addr;
                wr_data <= din;
                wr_wide <= word_mode;
            end
        end
    end

    // R10: a write cycle seen under low supply never produces a strobe
    a_r10_lowvdd_block: assert property (@(posedge clk) disable iff (rst)
        low_vdd |=> !wr_vld);

endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
    import flash_seq_pkg::*;
#(
    parameter int ABW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [ABW-1:0]    wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              start,
    output op_e               op
);

    cmd_st_e st;
    logic    key1;
    logic    key2;
    logic    take;

    assign take = wr_vld && !busy;
    assign key1 = (wr_data[BYTE_W-1:0] == CMD_KEY1) && (wr_addr[CMD_AW-1:0] == KEY_ADR1);
    assign key2 = (wr_data[BYTE_W-1:0] == CMD_KEY2) && (wr_addr[CMD_AW-1:0] == KEY_ADR2);

    always_comb begin
        op = OP_NONE;
        if (take) begin
            if (st == C_PGM)
                op = OP_PROG;
            else if (st == C_E3 && wr_data[BYTE_W-1:0] == CMD_SECT)
                op = OP_SERASE;
            else if (st == C_E3 && wr_data[BYTE_W-1:0] == CMD_CHIP)
                op = OP_CERASE;
        end
        start = (op != OP_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= C_READ;
        end else if (take) begin
            case (st)
                C_READ: st <= key1 ? C_K1 : C_READ;
                C_K1:   st <= key2 ? C_K2 : C_READ;
                C_K2: begin
                    if (wr_data[BYTE_W-1:0] == CMD_PROG)
                        st <= C_PGM;
                    else if (wr_data[BYTE_W-1:0] == CMD_ERASE)
                        st <= C_E1;
                    else
                        st <= C_READ;
                end
                C_E1:   st <= key1 ? C_E2 : C_READ;
                C_E2:   st <= key2 ? C_E3 : C_READ;
                default: st <= C_READ;
            endcase
        end
    end

    // R11: no operation is launched while the sequencer is busy
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    // R2: a launch always comes out of a completed prefix
    a_r2_start_after_prefix: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == C_PGM || st == C_E3));

endmodule

// File: rtl/flash_engine.sv
module flash_engine
    import flash_seq_pkg::*;
#(
    parameter int ABW       = 6,
    parameter int WAW       = 5,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 6,
    parameter int PRE_CYC   = 3,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               op,
    input  logic [ABW-1:0]    tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic              tgt_wide,
    input  logic [WAW-1:0]    rd_idx,
    output logic              busy,
    output logic              poll7,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << WAW;
    localparam int SWW   = WAW - SECT_BITS;
    localparam int CMAX  = (PROG_CYC > PRE_CYC)
                         ? ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC)
                         : ((PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC);
    localparam int CW    = $clog2(CMAX + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    eng_st_e           est;
    logic [CW-1:0]     cnt;
    logic [WAW-1:0]    idx;
    logic [WAW-1:0]    lo;
    logic [WAW-1:0]    last;
    logic [DATA_W-1:0] pdata;
    logic              pwide;
    logic              phi;
    logic [WAW-1:0]    t_idx;
    logic [SECT_BITS-1:0] t_sec;

    assign t_idx   = tgt_wide ? tgt_addr[WAW-1:0] : tgt_addr[WAW:1];
    assign t_sec   = t_idx[WAW-1:SWW];
    assign busy    = (est != E_IDLE);
    assign rd_word = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            est   <= E_IDLE;
            cnt   <= '0;
            idx   <= '0;
            lo    <= '0;
            last  <= '0;
            pdata <= '0;
            pwide <= 1'b1;
            phi   <= 1'b0;
            poll7 <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ERASED;
        end else begin
            case (est)
                E_IDLE: begin
                    if (start) begin
                        case (op)
                            OP_PROG: begin
                                est   <= E_PROG;
                                cnt   <= CW'(PROG_CYC - 1);
                                idx   <= t_idx;
                                pdata <= tgt_data;
                                pwide <= tgt_wide;
                                phi   <= !tgt_wide && tgt_addr[0];
                                poll7 <= !tgt_data[BYTE_W-1];
                            end
                            OP_SERASE: begin
                                est   <= E_SCAN;
                                lo    <= {t_sec, {SWW{1'b0}}};
                                last  <= {t_sec, {SWW{1'b1}}};
                                idx   <= {t_sec, {SWW{1'b0}}};
                                poll7 <= 1'b0;
                            end
                            OP_CERASE: begin
                                est   <= E_SCAN;
                                lo    <= '0;
                                last  <= '1;
                                idx   <= '0;
                                poll7 <= 1'b0;
                            end
                            default: est <= E_IDLE;
                        endcase
                    end
                end
                E_PROG: begin
                    if (cnt == '0) begin
                        mem[idx] <= prog_merge(mem[idx], pdata, pwide, phi);
                        est      <= E_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_SCAN: begin
                    if (mem[idx] != '0) begin
                        est <= E_PULSE;
                        cnt <= CW'(PRE_CYC - 1);
                    end else if (idx == last) begin
                        est <= E_ERASE;
                        cnt <= CW'(ERASE_CYC - 1);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                E_PULSE: begin
                    if (cnt == '0) begin
                        mem[idx] <= '0;
                        if (idx == last) begin
                            est <= E_ERASE;
                            cnt <= CW'(ERASE_CYC - 1);
                        end else begin
                            idx <= idx + 1'b1;
                            est <= E_SCAN;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_ERASE: begin
                    if (cnt == '0) begin
                        for (int i = 0; i < DEPTH; i++)
                            if (WAW'(i) >= lo && WAW'(i) <= last)
                                mem[i] <= ERASED;
                        est <= E_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: est <= E_IDLE;
            endcase
        end
    end

    // R7: a launch makes the sequencer busy on the next cycle
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8: the preprogram walk never leaves the target range
    a_r8_walk_in_range: assert property (@(posedge clk) disable iff (rst)
        (est == E_SCAN || est == E_PULSE) |-> (idx >= lo && idx <= last));

    // R9: a chip erase starts its walk at word zero
    a_r9_chip_from_zero: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_CERASE) |=> (idx == '0 && last == '1));

    // R12: a finished program returns to idle without a command
    a_r12_prog_returns: assert property (@(posedge clk) disable iff (rst)
        (est == E_PROG && cnt == '0) |=> !busy);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int WAW       = 5,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 6,
    parameter int PRE_CYC   = 3,
    parameter int ERASE_CYC = 20,
    localparam int ABW      = WAW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic              low_vdd,
    input  logic [ABW-1:0]    addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ready
);

    logic              wr_vld;
    logic [ABW-1:0]    wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_wide;
    logic              rd_start;
    logic              start;
    op_e               op;
    logic              busy;
    logic              poll7;
    logic [DATA_W-1:0] rd_word;
    logic [WAW-1:0]    rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] status;
    logic              tgl;

    flash_bus_if #(.ABW(ABW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .low_vdd  (low_vdd),
        .word_mode(word_mode),
        .addr     (addr),
        .din      (din),
        .wr_vld   (wr_vld),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_wide  (wr_wide),
        .rd_start (rd_start)
    );

    flash_cmd_dec #(.ABW(ABW)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_vld (wr_vld),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .busy   (busy),
        .start  (start),
        .op     (op)
    );

    flash_engine #(
        .ABW      (ABW),
        .WAW      (WAW),
        .SECT_BITS(SECT_BITS),
        .PROG_CYC (PROG_CYC),
        .PRE_CYC  (PRE_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op      (op),
        .tgt_addr(wr_addr),
        .tgt_data(wr_data),
        .tgt_wide(wr_wide),
        .rd_idx  (rd_idx),
        .busy    (busy),
        .poll7   (poll7),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tgl <= 1'b0;
        else if (rd_start && busy)
            tgl <= !tgl;
    end

    assign rd_idx  = word_mode ? addr[WAW-1:0] : addr[WAW:1];
    assign rd_byte = addr[0] ? rd_word[DATA_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    assign status  = {poll7, tgl, {(BYTE_W-2){1'b0}}};
    assign ready   = !busy;

    always_comb begin
        if (ce_n || oe_n)
            dout = '0;
        else if (busy)
            dout = {{(DATA_W-BYTE_W){1'b0}}, status};
        else if (word_mode)
            dout = rd_word;
        else
            dout = {{(DATA_W-BYTE_W){1'b0}}, rd_byte};
    end

    // R6: the toggle bit holds still whenever the sequencer was idle
    a_r6_toggle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(tgl));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    import flash_seq_pkg::*;

    localparam int PROG_CYC  = 6;
    localparam int PRE_CYC   = 3;
    localparam int ERASE_CYC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        word_mode = 1'b1;
    logic        low_vdd = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(
        .PROG_CYC (PROG_CYC),
        .PRE_CYC  (PRE_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .low_vdd(low_vdd), .addr(addr), .din(din),
        .dout(dout), .ready(ready)
    );

    // {word_mode, addr, data, expected readback in the same mode}
    localparam logic [38:0] VEC [6] = '{
        {1'b1, 6'd3,  16'h1234, 16'h1234},
        {1'b1, 6'd3,  16'hFF0F, 16'h1204},  // R4: already-cleared bits stay 0
        {1'b0, 6'd18, 16'h005A, 16'h005A},
        {1'b0, 6'd19, 16'h00A5, 16'h00A5},
        {1'b1, 6'd0,  16'h0000, 16'h0000},
        {1'b1, 6'd20, 16'h8000, 16'h8000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic wm, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        word_mode = wm; addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic bus_rd(input logic wm, input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        word_mode = wm; addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic keys(input logic wm);
        bus_wr(wm, 6'h05, 16'h00AA);
        bus_wr(wm, 6'h0A, 16'h0055);
    endtask

    task automatic prog_seq(input logic wm, input logic [5:0] a, input logic [15:0] d);
        keys(wm);
        bus_wr(wm, 6'h05, 16'h00A0);
        bus_wr(wm, a, d);
    endtask

    task automatic erase_seq(input logic [7:0] code, input logic [5:0] a);
        keys(1'b1);
        bus_wr(1'b1, 6'h05, 16'h0080);
        keys(1'b1);
        bus_wr(1'b1, a, {8'h00, code});
    endtask

    // Holds a read open through the operation; counts busy cycles and DQ7 misses.
    task automatic measure(input logic wm, input logic [5:0] a, input logic exp7,
                           output int n, output int bad7, output logic [15:0] fin);
        word_mode = wm; addr = a; ce_n = 1'b0; oe_n = 1'b0;
        n = 0; bad7 = 0;
        @(negedge clk);
        while (!ready && n < 2000) begin
            if (dout[7] !== exp7 || dout[5:0] !== 6'd0 || dout[15:8] !== 8'd0) bad7++;
            n++;
            @(negedge clk);
        end
        fin = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2, t1, t2, t3;
        int n, bad;
        logic [15:0] fin;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 ready", ready, 1);
        bus_rd(1'b1, 6'd0, v);  check("R1 word erased", v, 16'hFFFF);
        bus_rd(1'b0, 6'd1, v);  check("R1 byte erased", v, 16'h00FF);

        // R2/R3/R4/R5/R7/R12: program table
        for (int k = 0; k < 6; k++) begin
            logic        wm;
            logic [5:0]  a;
            logic [15:0] d, e;
            {wm, a, d, e} = VEC[k];
            prog_seq(wm, a, d);
            measure(wm, a, !d[7], n, bad, fin);
            check("R7 program busy cycles", n, PROG_CYC);
            check("R5 program poll status", bad, 0);
            check("R12 true data after done", fin, e);
            bus_rd(wm, a, v);
            check("R2 program readback", v, e);
        end
        bus_rd(1'b1, 6'd9, v);  check("R3 both bytes in word", v, 16'hA55A);
        bus_rd(1'b0, 6'd7, v);  check("R3 high byte of word 3", v, 16'h0012);
        bus_rd(1'b1, 6'd35, v); check("R3 addr bit5 ignored in word mode", v, 16'h1204);
        bus_rd(1'b1, 6'd3, v);  check("R4 AND merge", v, 16'h1204);

        // R6/R5/R11: activity during a sector erase of sector 3
        erase_seq(CMD_SECT, 6'd26);
        @(negedge clk);
        check("R7 ready low after erase command", ready, 0);
        bus_rd(1'b1, 6'd26, t1);
        bus_rd(1'b1, 6'd26, t2);
        bus_rd(1'b1, 6'd26, t3);
        check("R6 toggle first pair", t1[6] ^ t2[6], 1);
        check("R6 toggle second pair", t2[6] ^ t3[6], 1);
        check("R5 erase poll bit", {t1[7], t2[7], t3[7]}, 3'b000);
        prog_seq(1'b1, 6'd13, 16'h0000);   // R11: must be ignored while busy
        check("R11 still busy during ignored writes", ready, 0);
        n = 0;
        while (!ready && n < 2000) begin n++; @(negedge clk); end
        bus_rd(1'b1, 6'd13, v); check("R11 write during busy ignored", v, 16'hFFFF);
        bus_rd(1'b1, 6'd9, v);
        bus_rd(1'b1, 6'd9, v2);
        check("R6 idle reads stable", {v, v2}, {16'hA55A, 16'hA55A});

        // R8: sector 0 holds one zero word (word 0) and seven nonzero words
        erase_seq(CMD_SECT, 6'd2);
        measure(1'b1, 6'd2, 1'b0, n, bad, fin);
        check("R8 sector erase busy cycles", n, 8 + 7 * PRE_CYC + ERASE_CYC);
        check("R5 erase poll during measure", bad, 0);
        bad = 0;
        for (int w = 0; w < 8; w++) begin
            bus_rd(1'b1, 6'(w), v);
            if (v !== 16'hFFFF) bad++;
        end
        check("R8 sector 0 erased", bad, 0);
        bus_rd(1'b1, 6'd9, v);  check("R8 sector 1 untouched", v, 16'hA55A);
        bus_rd(1'b1, 6'd20, v); check("R8 sector 2 untouched", v, 16'h8000);

        // R10: low supply blocks a full program sequence
        low_vdd = 1'b1;
        prog_seq(1'b1, 6'd14, 16'h0000);
        @(negedge clk);
        check("R10 no start under low supply", ready, 1);
        low_vdd = 1'b0;
        bus_rd(1'b1, 6'd14, v); check("R10 array unchanged", v, 16'hFFFF);

        // R11: a wrong third write aborts the sequence
        keys(1'b1);
        bus_wr(1'b1, 6'h05, 16'h0077);
        bus_wr(1'b1, 6'd15, 16'h0000);
        @(negedge clk);
        check("R11 bad sequence starts nothing", ready, 1);
        bus_rd(1'b1, 6'd15, v); check("R11 bad sequence no write", v, 16'hFFFF);

        // R9: chip erase, all 32 words nonzero
        erase_seq(CMD_CHIP, 6'd0);
        measure(1'b1, 6'd0, 1'b0, n, bad, fin);
        check("R9 chip erase busy cycles", n, 32 + 32 * PRE_CYC + ERASE_CYC);
        bad = 0;
        for (int w = 0; w < 32; w++) begin
            bus_rd(1'b1, 6'(w), v);
            if (v !== 16'hFFFF) bad++;
        end
        check("R9 whole array erased", bad, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule